// File: doc/BRIEF.md
# Boot-Time Key Integrity Checker and Exporter

This block runs once after every reset and guards a set of protected 256-bit keys held in a one-time-programmable array. The array lives outside the block and is reached through a plain word-wide read port. For each slot the block reads the eight key words and counts their zero bits. It then reads the slot's stored zero-count word and compares the two values. The cells of the array can only be burned from 0 to 1, so any later change to a key lowers its zero count and can no longer match the stored value.

The block releases keys only when every slot has passed. It then streams all slots, one 32-bit word at a time, over a private valid/ready port to a downstream keyslot store. Each word carries its slot and word index. If any slot fails, the block raises a sticky error, exports nothing, and reports completion at once. No bus-visible path to the key material exists.

Top module: `otp_key_guard`

## Requirements
- R1: While reset is held and in the first cycle after release, `otp_addr` is 0 and `done`, `integrity_error` and `exp_valid` are all low.
- R2: Slot s occupies array words s*9 to s*9+8: words 0 to 7 are the key (word 0 first) and word 8 holds the zero-count. During the check the block reads addresses 0, 1, 2, ... with one new address each cycle, so the whole check of 8 slots takes 72 cycles.
- R3: A slot passes when the number of 0 bits across its 256 key bits equals bits [8:0] of its count word. Bits [31:9] of the count word are ignored.
- R4: A mismatch in slot k raises `integrity_error` and `done` in cycle 9*k+9 after reset release. Both stay high until the next reset, and `exp_valid` is never asserted in that run.
- R5: `exp_valid` stays low until all slots have passed. The first export word appears in cycle 72 after reset release.
- R6: Export sends slot 0 through 7 in order, and words 0 through 7 of each slot in order. `exp_data` equals that key word, and `exp_slot`/`exp_word` give its indices.
- R7: While `exp_valid` is high and `exp_ready` is low, `exp_valid`, `exp_data`, `exp_slot` and `exp_word` hold their values.
- R8: In the cycle after the 64th word is accepted, `done` is high and `exp_valid` is low, and `done` then stays high until reset.
- R9: The extreme counts are handled: an all-zero key with count 256 passes, and an all-ones key with count 0 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| otp_addr | output | 7 | Word address into the key array |
| otp_rdata | input | 32 | Word read from the array at `otp_addr` (combinational) |
| exp_valid | output | 1 | Export word is valid |
| exp_ready | input | 1 | Downstream store accepts the word |
| exp_data | output | 32 | Key word being exported |
| exp_slot | output | 3 | Slot index of the exported word |
| exp_word | output | 3 | Word index within the slot |
| done | output | 1 | Check and export finished, or check failed |
| integrity_error | output | 1 | Sticky: a slot failed the zero-count check |

## Verification
The assertions check on every cycle the following properties:
- the error is sticky and implies completion;
- export never overlaps an error or completion;
- the export indices hold while stalled, and advance by one word after each accepted transfer;
- the array address stays within range.

Only the bench scenarios can show the rest:
- that a correct count really passes and a single burned bit really fails, including at the 0 and 256 extremes;
- that the upper count bits are ignored;
- that the exported data equals the stored keys in slot and word order;
- the exact cycles at which the error and the first export word appear.

// File: rtl/okg_pkg.sv
package okg_pkg;

    typedef enum logic [2:0] {
        ST_KEY  = 3'd0,
        ST_CNT  = 3'd1,
        ST_EXP  = 3'd2,
        ST_DONE = 3'd3,
        ST_FAIL = 3'd4
    } okg_state_e;

endpackage

// File: rtl/okg_zero_pop.sv
module okg_zero_pop #(
    parameter int WORD_W = 32,
    localparam int ZW = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [ZW-1:0]     zeros_o
);

    always_comb begin
        zeros_o = '0;
        for (int b = 0; b < WORD_W; b++) begin
            zeros_o = zeros_o + ZW'(~word_i[b]);
        end
    end

endmodule

// File: rtl/okg_seq.sv
module okg_seq
    import okg_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int WORD_W    = 32,
    parameter int KEY_W     = 256,
    localparam int WORDS    = KEY_W / WORD_W,
    localparam int STRIDE   = WORDS + 1,
    localparam int CNT_W    = $clog2(KEY_W + 1),
    localparam int ZW       = $clog2(WORD_W + 1),
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int ADDR_W   = $clog2(NUM_SLOTS * STRIDE)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ZW-1:0]     zeros_i,
    input  logic [CNT_W-1:0]  stored_cnt_i,
    input  logic              exp_ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              exp_valid_o,
    output logic [SLOT_W-1:0] exp_slot_o,
    output logic [WIDX_W-1:0] exp_word_o,
    output logic              done_o,
    output logic              error_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);

    typedef struct packed {
        okg_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [WIDX_W-1:0] word;
        logic [CNT_W-1:0]  acc;
    } seq_t;

    seq_t q, d;

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            ST_KEY: begin
                d.acc = q.acc + CNT_W'(zeros_i);
                if (q.word == LAST_WORD) begin
                    d.st   = ST_CNT;
                    d.word = '0;
                end else begin
                    d.word = q.word + 1'b1;
                end
            end
            ST_CNT: begin
                if (q.acc != stored_cnt_i) begin
                    d.st = ST_FAIL;
                end else begin
                    d.acc = '0;
                    if (q.slot == LAST_SLOT) begin
                        d.st   = ST_EXP;
                        d.slot = '0;
                        d.word = '0;
                    end else begin
                        d.st   = ST_KEY;
                        d.slot = q.slot + 1'b1;
                    end
                end
            end
            ST_EXP: begin
                if (exp_ready_i) begin
                    if (q.word == LAST_WORD) begin
                        d.word = '0;
                        if (q.slot == LAST_SLOT) begin
                            d.st = ST_DONE;
                        end else begin
                            d.slot = q.slot + 1'b1;
                        end
                    end else begin
                        d.word = q.word + 1'b1;
                    end
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_KEY, slot: '0, word: '0, acc: '0};
        end else begin
            q <= d;
        end
    end

    // array address: key words, then the count word of the slot
    logic [ADDR_W-1:0] widx_addr;
    always_comb begin
        widx_addr = (q.st == ST_CNT) ? ADDR_W'(WORDS) : ADDR_W'(q.word);
        addr_o    = ADDR_W'(ADDR_W'(q.slot) * ADDR_W'(STRIDE) + widx_addr);
    end

    assign exp_valid_o = (q.st == ST_EXP);
    assign exp_slot_o  = q.slot;
    assign exp_word_o  = q.word;
    assign done_o      = (q.st == ST_DONE) || (q.st == ST_FAIL);
    assign error_o     = (q.st == ST_FAIL);

endmodule

// File: rtl/otp_key_guard.sv
module otp_key_guard #(
    parameter int NUM_SLOTS = 8,
    parameter int WORD_W    = 32,
    parameter int KEY_W     = 256,
    localparam int WORDS    = KEY_W / WORD_W,
    localparam int STRIDE   = WORDS + 1,
    localparam int CNT_W    = $clog2(KEY_W + 1),
    localparam int ZW       = $clog2(WORD_W + 1),
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int ADDR_W   = $clog2(NUM_SLOTS * STRIDE)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [ADDR_W-1:0] otp_addr,
    input  logic [WORD_W-1:0] otp_rdata,
    output logic              exp_valid,
    input  logic              exp_ready,
    output logic [WORD_W-1:0] exp_data,
    output logic [SLOT_W-1:0] exp_slot,
    output logic [WIDX_W-1:0] exp_word,
    output logic              done,
    output logic              integrity_error
);

    logic [ZW-1:0] zeros;

    okg_zero_pop #(.WORD_W(WORD_W)) pop_i (
        .word_i  (otp_rdata),
        .zeros_o (zeros)
    );

    okg_seq #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORD_W    (WORD_W),
        .KEY_W     (KEY_W)
    ) seq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .zeros_i      (zeros),
        .stored_cnt_i (otp_rdata[CNT_W-1:0]),
        .exp_ready_i  (exp_ready),
        .addr_o       (otp_addr),
        .exp_valid_o  (exp_valid),
        .exp_slot_o   (exp_slot),
        .exp_word_o   (exp_word),
        .done_o       (done),
        .error_o      (integrity_error)
    );

    // export words come straight from the private array read path
    assign exp_data = otp_rdata;

endmodule

// File: rtl/okg_guard_chk.sv
module okg_guard_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int WORDS     = 8,
    parameter int SLOT_W    = 3,
    parameter int WIDX_W    = 3,
    parameter int ADDR_W    = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] otp_addr,
    input logic              exp_valid,
    input logic              exp_ready,
    input logic [SLOT_W-1:0] exp_slot,
    input logic [WIDX_W-1:0] exp_word,
    input logic              done,
    input logic              integrity_error
);

    assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        integrity_error |=> integrity_error && done);

    assert_err_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        integrity_error |-> done && !exp_valid);

    assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |=> done);

    assert_no_export_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |-> !exp_valid);

    assert_hold_on_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exp_valid && !exp_ready) |=> exp_valid && $stable(exp_slot) && $stable(exp_word));

    assert_word_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exp_valid && exp_ready && (exp_word != WIDX_W'(WORDS - 1)))
        |=> exp_valid && (exp_word == $past(exp_word) + 1'b1) && $stable(exp_slot));

    assert_slot_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exp_valid |-> (int'(exp_slot) < NUM_SLOTS));

    assert_addr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(otp_addr) < NUM_SLOTS * (WORDS + 1));

endmodule

bind otp_key_guard okg_guard_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .WORDS     (WORDS),
    .SLOT_W    (SLOT_W),
    .WIDX_W    (WIDX_W),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .otp_addr        (otp_addr),
    .exp_valid       (exp_valid),
    .exp_ready       (exp_ready),
    .exp_slot        (exp_slot),
    .exp_word        (exp_word),
    .done            (done),
    .integrity_error (integrity_error)
);

// File: tb/otp_key_guard_tb_top.sv
module otp_key_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS    = 8;
    localparam int NW    = 8;
    localparam int DEPTH = NS * (NW + 1);

    typedef struct packed {
        logic [31:0] seed;
        logic [1:0]  kind;   // 0 pseudo-random, 1 all zero, 2 all ones
        logic [3:0]  bad;    // slot to tamper, 4'hF none
        logic        junk;   // garbage in count-word upper bits
        logic        stall;  // throttle exp_ready
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 2'd0, 4'hF, 1'b0, 1'b0},
        '{32'h9E37_79B9, 2'd0, 4'hF, 1'b1, 1'b1},
        '{32'h0000_0001, 2'd1, 4'hF, 1'b1, 1'b0},
        '{32'h0000_0002, 2'd2, 4'hF, 1'b0, 1'b1},
        '{32'hDEAD_BEEF, 2'd0, 4'h0, 1'b0, 1'b0},
        '{32'hCAFE_F00D, 2'd0, 4'h7, 1'b1, 1'b0},
        '{32'h0BAD_5EED, 2'd0, 4'h3, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready = 1'b0;
    logic [6:0]  otp_addr;
    logic [31:0] otp_rdata;
    logic        exp_valid;
    logic [31:0] exp_data;
    logic [2:0]  exp_slot;
    logic [2:0]  exp_word;
    logic        done;
    logic        integrity_error;

    logic [31:0] mem [DEPTH];
    logic [31:0] keys [DEPTH];   // untampered key copy for export comparison

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign otp_rdata = (int'(otp_addr) < DEPTH) ? mem[otp_addr] : 32'h0;

    otp_key_guard dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .otp_addr        (otp_addr),
        .otp_rdata       (otp_rdata),
        .exp_valid       (exp_valid),
        .exp_ready       (ready),
        .exp_data        (exp_data),
        .exp_slot        (exp_slot),
        .exp_word        (exp_word),
        .done            (done),
        .integrity_error (integrity_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] burn_one(input logic [31:0] w);
        for (int b = 0; b < 32; b++) begin
            if (!w[b]) return w | (32'h1 << b);
        end
        return w;
    endfunction

    task automatic fill(input vec_t v);
        logic [31:0] r;
        int zc;
        r = v.seed;
        for (int s = 0; s < NS; s++) begin
            zc = 0;
            for (int w = 0; w < NW; w++) begin
                r = xs(r);
                case (v.kind)
                    2'd1:    mem[s*9+w] = 32'h0;
                    2'd2:    mem[s*9+w] = 32'hFFFF_FFFF;
                    default: mem[s*9+w] = r;
                endcase
                keys[s*9+w] = mem[s*9+w];
                zc += 32 - $countones(mem[s*9+w]);
            end
            mem[s*9+8] = 32'(zc) | (v.junk ? ((r | 32'h8000_0000) & 32'hFFFF_FE00) : 32'h0);
            if (int'(v.bad) == s) mem[s*9+2] = burn_one(mem[s*9+2]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ready = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(otp_addr == 7'd0 && !done && !integrity_error && !exp_valid,
              "R1", "outputs during reset",
              {otp_addr, done, integrity_error, exp_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        bit   expect_err;
        int   n, xfers, first_valid, done_cyc, bad_addr;
        bit   prev_stall;
        logic [31:0] h_data;
        logic [2:0]  h_slot, h_word;
        v = VECS[idx];
        expect_err = (v.bad != 4'hF);
        fill(v);
        do_reset();
        n = 0; xfers = 0; first_valid = -1; done_cyc = -1; bad_addr = 0;
        prev_stall = 1'b0;
        h_data = '0; h_slot = '0; h_word = '0;
        while (n < 400) begin
            #1;
            if (n == 0)
                check(otp_addr == 7'd0 && !done && !integrity_error && !exp_valid,
                      "R1", "first cycle after reset",
                      {otp_addr, done, integrity_error, exp_valid}, 0);
            if (!expect_err && n < DEPTH && int'(otp_addr) != n) bad_addr++;
            if (prev_stall)
                check(exp_valid && exp_data == h_data && exp_slot == h_slot && exp_word == h_word,
                      "R7", "hold while stalled", {exp_slot, exp_word, exp_data},
                      {h_slot, h_word, h_data});
            if (exp_valid && first_valid < 0) first_valid = n;
            if (done) begin
                done_cyc = n;
                break;
            end
            ready = v.stall ? ((n % 3) != 0) : 1'b1;
            if (exp_valid) begin
                if (ready) begin
                    check(exp_slot == 3'(xfers / NW) && exp_word == 3'(xfers % NW)
                          && exp_data == keys[(xfers / NW) * 9 + (xfers % NW)],
                          "R6", $sformatf("export word %0d", xfers),
                          {exp_slot, exp_word, exp_data},
                          {3'(xfers / NW), 3'(xfers % NW), keys[(xfers / NW) * 9 + (xfers % NW)]});
                    xfers++;
                end
                prev_stall = !ready;
                h_data = exp_data; h_slot = exp_slot; h_word = exp_word;
            end else begin
                prev_stall = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        if (expect_err) begin
            check(integrity_error && done_cyc == 9 * int'(v.bad) + 9, "R4",
                  "error flag and cycle", done_cyc, 9 * int'(v.bad) + 9);
            check(first_valid < 0 && xfers == 0, "R4", "no export on failure", xfers, 0);
        end else begin
            check(!integrity_error, "R3", $sformatf("vector %0d passes", idx),
                  integrity_error, 0);
            check(bad_addr == 0, "R2", "check-phase read order", bad_addr, 0);
            check(first_valid == DEPTH, "R5", "first export cycle", first_valid, DEPTH);
            check(xfers == NS * NW && !exp_valid, "R8", "done after last word",
                  xfers, NS * NW);
            if (v.kind != 2'd0)
                check(!integrity_error && xfers == NS * NW, "R9",
                      "extreme zero count", xfers, NS * NW);
        end
        ready = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check(done && !exp_valid && integrity_error == expect_err, "R8",
              "done holds", {done, exp_valid, integrity_error}, {1'b1, 1'b0, expect_err});
    endtask

    initial begin
        for (int i = 0; i < NV; i++) run_vec(i);

        // directed: count word one too high (stored count off by one) fails slot 5
        fill(VECS[0]);
        mem[5*9+8] = mem[5*9+8] + 32'd1;
        do_reset();
        repeat (60) @(negedge clk);
        #1;
        check(integrity_error && done, "R3", "off-by-one count rejected",
              {integrity_error, done}, 2'b11);

        // directed: reset after failure clears the sticky error
        fill(VECS[0]);
        do_reset();
        #1;
        check(!integrity_error && !done, "R4", "error cleared by reset",
              {integrity_error, done}, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule